// File: doc/BRIEF.md
# Mailbox Virtual-Register Access Engine

This block sits on the embedded-controller side of a small host I/O window. The window has ten byte offsets. Through it the host reaches a private virtual register file, which is addressed with 16 bits. The host never touches that file directly. It fills a shared mailbox buffer through a movable pointer and then rings a doorbell. The engine takes a snapshot of the request at the doorbell, waits a programmable number of clock cycles, and performs one single-byte read or write on the register file. When the access is done, it returns any read data into the mailbox, posts a status byte and raises a completion interrupt bit. Software clears the status byte and the interrupt bit by writing ones to them.

A request packet sits in mailbox region 1, which starts at pointer value 0x8000:

- byte 0 holds the command;
- byte 1 holds the entry count;
- byte 4 holds the value;
- bytes 6 and 7 hold the low and high register address.

A range of register pairs behaves as 16-bit quantities. Reading the low byte of a pair freezes the high byte of that pair, so a later read of the high byte returns a value that is consistent with the low byte.

Top module: `mbx_vreg_engine`

## Requirements
- R1: After reset, `host_rdata`, `irq`, the status byte (offset 1), the interrupt source byte (offset 8) and the pointer (offsets 2 and 3) are all zero.
- R2: Offset 2 holds the pointer low byte and offset 3 holds the pointer high byte; both read back as written. Offsets 4 to 7 give access to mailbox bytes pointer+0 to pointer+3, but only when that address has bit 15 set and bits 14..MBX_AW equal to zero. Any other address reads as 0x00, and a write to it is dropped.
- R3: Command 0x02 reads a byte. After completion, mailbox byte 4 holds the addressed register, offset 1 reads 0x01 and bit 0 of offset 8 is set.
- R4: Command 0x03 writes a byte. Mailbox byte 4 is stored into the addressed register, and completion posts status 0x01 and sets bit 0 of offset 8.
- R5: Any other command completes with status 0x80 and sets bit 0 of offset 8. It leaves both the register file and mailbox byte 4 unchanged.
- R6: A write to offset 0 starts a request only when its data is 0x01 and the engine is idle. A write of any other value, or a doorbell while a request is in flight, produces no completion.
- R7: Offsets 1 and 8 clear each bit written as 1. A completion in the same cycle as a clear takes priority.
- R8: Register pairs occupy PAIR_BASE to PAIR_BASE+2*PAIR_COUNT-1, with the low byte at the even address.
  - A read of a low byte latches the current high byte of that pair.
  - A following read of that high byte returns the latched value, even if the high byte was rewritten after the latch.
  - A high-byte read of a pair whose low byte was not the last one latched returns the stored byte.
- R9: Only the low VREG_AW bits of the 16-bit register address select a register. The upper bits are ignored.
- R10: `irq` is high exactly while bit 0 of offset 8 is set.
- R11: Let cycle 0 be the doorbell clock edge. Bit 0 of offset 8 becomes set at a clock edge between LATENCY+2 and LATENCY+5 after it; a latching pair read takes the longest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 4 | Window byte offset (0 to 9 used) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data for the offset presented in the previous cycle |
| irq | output | 1 | Command-complete interrupt level |

## Verification
Writes and reads are tried on several register addresses, including the lowest and the highest register and an address with high bits set. Reading the same location back separates a real store from a dropped write, and it exposes address aliasing in the upper bits.

The pair sequences do three things:
- they rewrite the high byte between the two reads, which separates a latched value from a direct one;
- they read a high byte of a pair that was not latched;
- they re-latch a pair after a rewrite.

Unknown command codes, doorbells with the wrong value and doorbells sent while busy are followed by a quiet wait and a readback. This shows that nothing changed. Pointer tests cover in-region offsets, addresses outside region 1 and addresses past the end of the buffer.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACCESS,
    ST_CAPTURE,
    ST_LATCH_RD,
    ST_LATCH_CAP,
    ST_DONE
  } eng_state_t;

  localparam logic [7:0] CMD_RD      = 8'h02;
  localparam logic [7:0] CMD_WR      = 8'h03;
  localparam logic [7:0] STAT_OK     = 8'h01;
  localparam logic [7:0] STAT_BADCMD = 8'h80;
  localparam logic [7:0] DOORBELL_GO = 8'h01;

  localparam logic [3:0] OFS_DOORBELL = 4'd0;
  localparam logic [3:0] OFS_STATUS   = 4'd1;
  localparam logic [3:0] OFS_PTR_LO   = 4'd2;
  localparam logic [3:0] OFS_PTR_HI   = 4'd3;
  localparam logic [3:0] OFS_IRQSRC   = 4'd8;

  localparam int MBX_CMD_IDX    = 0;
  localparam int MBX_VAL_IDX    = 4;
  localparam int MBX_ADR_LO_IDX = 6;
  localparam int MBX_ADR_HI_IDX = 7;

endpackage

// File: rtl/mbx_vreg_file.sv
module mbx_vreg_file #(
  parameter int VREG_AW = 8
) (
  input  logic               clk,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [VREG_AW-1:0] addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata
);

  localparam int DEPTH = 1 << VREG_AW;

  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  // Single port, synchronous read: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
  import mbx_pkg::*;
#(
  parameter int MBX_AW  = 4,
  parameter int VREG_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic [3:0]         host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  output logic               irq,
  output logic               doorbell,
  output logic [7:0]         req_cmd,
  output logic [7:0]         req_val,
  output logic [VREG_AW-1:0] req_addr,
  input  logic               eng_resp_we,
  input  logic [7:0]         eng_resp_data,
  input  logic               eng_done,
  input  logic [7:0]         eng_status
);

  localparam int MBX_BYTES = 1 << MBX_AW;
  localparam int WIN_BYTES = 4;

  logic [7:0]        mbx_q [MBX_BYTES];
  logic [15:0]       ptr_q;
  logic [7:0]        stat_q, isr_q, rdata_q;
  logic [7:0]        stat_nx, isr_nx, rd_mux;
  logic [MBX_AW-1:0] win_idx [WIN_BYTES];
  logic              win_hit [WIN_BYTES];
  logic [7:0]        win_rd  [WIN_BYTES];
  logic              wr_win;
  logic [1:0]        wr_k;

  // Each window byte resolves to pointer + k inside region 1.
  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_win
    logic [15:0] loc;
    assign loc        = ptr_q + 16'(k);
    assign win_hit[k] = loc[15] && (loc[14:MBX_AW] == '0);
    assign win_idx[k] = loc[MBX_AW-1:0];
    assign win_rd[k]  = win_hit[k] ? mbx_q[win_idx[k]] : 8'h00;
  end

  assign wr_win = host_wr && (host_addr[3:2] == 2'b01);
  assign wr_k   = host_addr[1:0];

  // Write-one-to-clear, with a completion taking priority over a clear.
  always_comb begin
    stat_nx = stat_q;
    isr_nx  = isr_q;
    if (host_wr && host_addr == OFS_STATUS) stat_nx = stat_q & ~host_wdata;
    if (host_wr && host_addr == OFS_IRQSRC) isr_nx  = isr_q & ~host_wdata;
    if (eng_done) begin
      stat_nx   = eng_status;
      isr_nx[0] = 1'b1;
    end
  end

  always_comb begin
    case (host_addr)
      OFS_STATUS: rd_mux = stat_q;
      OFS_PTR_LO: rd_mux = ptr_q[7:0];
      OFS_PTR_HI: rd_mux = ptr_q[15:8];
      4'd4:       rd_mux = win_rd[0];
      4'd5:       rd_mux = win_rd[1];
      4'd6:       rd_mux = win_rd[2];
      4'd7:       rd_mux = win_rd[3];
      OFS_IRQSRC: rd_mux = isr_q;
      default:    rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      stat_q  <= '0;
      isr_q   <= '0;
      rdata_q <= '0;
      for (int i = 0; i < MBX_BYTES; i++) mbx_q[i] <= '0;
    end else begin
      stat_q  <= stat_nx;
      isr_q   <= isr_nx;
      rdata_q <= rd_mux;
      if (host_wr && host_addr == OFS_PTR_LO) ptr_q[7:0]  <= host_wdata;
      if (host_wr && host_addr == OFS_PTR_HI) ptr_q[15:8] <= host_wdata;
      if (wr_win && win_hit[wr_k]) mbx_q[win_idx[wr_k]] <= host_wdata;
      if (eng_resp_we) mbx_q[MBX_VAL_IDX] <= eng_resp_data;
    end
  end

  assign host_rdata = rdata_q;
  assign irq        = isr_q[0];
  assign doorbell   = host_wr && (host_addr == OFS_DOORBELL) && (host_wdata == DOORBELL_GO);
  assign req_cmd    = mbx_q[MBX_CMD_IDX];
  assign req_val    = mbx_q[MBX_VAL_IDX];
  assign req_addr   = VREG_AW'({mbx_q[MBX_ADR_HI_IDX], mbx_q[MBX_ADR_LO_IDX]});

endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int LATENCY    = 32,
  parameter int VREG_AW    = 8,
  parameter int PAIR_BASE  = 64,
  parameter int PAIR_COUNT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               doorbell,
  input  logic [7:0]         req_cmd,
  input  logic [7:0]         req_val,
  input  logic [VREG_AW-1:0] req_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [VREG_AW-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               resp_we,
  output logic [7:0]         resp_data,
  output logic               done,
  output logic [7:0]         status,
  output logic               busy
);

  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [VREG_AW:0] P_LO = (VREG_AW+1)'(PAIR_BASE);
  localparam logic [VREG_AW:0] P_HI = (VREG_AW+1)'(PAIR_BASE + 2 * PAIR_COUNT);

  eng_state_t         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [7:0]         cmd_q, val_q, data_q, stat_q, sh_q;
  logic [VREG_AW-1:0] adr_q;
  logic [VREG_AW-2:0] sh_tag_q;
  logic               sh_vld_q, rd_ok_q;
  logic               in_pairs, is_low, is_high, sh_match;

  assign in_pairs = ({1'b0, adr_q} >= P_LO) && ({1'b0, adr_q} < P_HI);
  assign is_low   = in_pairs && !adr_q[0];
  assign is_high  = in_pairs && adr_q[0];
  assign sh_match = sh_vld_q && (sh_tag_q == adr_q[VREG_AW-1:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cmd_q    <= '0;
      val_q    <= '0;
      adr_q    <= '0;
      data_q   <= '0;
      stat_q   <= '0;
      rd_ok_q  <= 1'b0;
      sh_q     <= '0;
      sh_tag_q <= '0;
      sh_vld_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (doorbell) begin
          cmd_q   <= req_cmd;
          val_q   <= req_val;
          adr_q   <= req_addr;
          cnt_q   <= '0;
          rd_ok_q <= 1'b0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_q == CNT_W'(LATENCY - 1)) state_q <= ST_ACCESS;
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_ACCESS: begin
          if (cmd_q == CMD_RD) begin
            state_q <= ST_CAPTURE;
          end else begin
            stat_q  <= (cmd_q == CMD_WR) ? STAT_OK : STAT_BADCMD;
            state_q <= ST_DONE;
          end
        end
        ST_CAPTURE: begin
          data_q  <= (is_high && sh_match) ? sh_q : mem_rdata;
          stat_q  <= STAT_OK;
          rd_ok_q <= 1'b1;
          state_q <= is_low ? ST_LATCH_RD : ST_DONE;
        end
        ST_LATCH_RD: state_q <= ST_LATCH_CAP;
        ST_LATCH_CAP: begin
          sh_q     <= mem_rdata;
          sh_tag_q <= adr_q[VREG_AW-1:1];
          sh_vld_q <= 1'b1;
          state_q  <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // The companion byte is fetched in a second RAM cycle, so one port suffices.
  assign mem_rd    = ((state_q == ST_ACCESS) && (cmd_q == CMD_RD)) || (state_q == ST_LATCH_RD);
  assign mem_wr    = (state_q == ST_ACCESS) && (cmd_q == CMD_WR);
  assign mem_addr  = (state_q == ST_LATCH_RD) ? (adr_q | VREG_AW'(1)) : adr_q;
  assign mem_wdata = val_q;
  assign done      = (state_q == ST_DONE);
  assign resp_we   = done && rd_ok_q;
  assign resp_data = data_q;
  assign status    = stat_q;
  assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/mbx_vreg_engine.sv
module mbx_vreg_engine #(
  parameter int MBX_AW     = 4,
  parameter int VREG_AW    = 8,
  parameter int LATENCY    = 32,
  parameter int PAIR_BASE  = 64,
  parameter int PAIR_COUNT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq
);

  logic               doorbell, eng_done, busy, resp_we, mem_rd, mem_wr;
  logic [7:0]         req_cmd, req_val, resp_data, eng_status, mem_wdata, mem_rdata;
  logic [VREG_AW-1:0] req_addr, mem_addr;

  mbx_host_port #(.MBX_AW(MBX_AW), .VREG_AW(VREG_AW)) u_port (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq),
    .doorbell(doorbell), .req_cmd(req_cmd), .req_val(req_val), .req_addr(req_addr),
    .eng_resp_we(resp_we), .eng_resp_data(resp_data),
    .eng_done(eng_done), .eng_status(eng_status)
  );

  mbx_engine #(
    .LATENCY(LATENCY), .VREG_AW(VREG_AW),
    .PAIR_BASE(PAIR_BASE), .PAIR_COUNT(PAIR_COUNT)
  ) u_eng (
    .clk(clk), .rst(rst),
    .doorbell(doorbell), .req_cmd(req_cmd), .req_val(req_val), .req_addr(req_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .resp_we(resp_we), .resp_data(resp_data),
    .done(eng_done), .status(eng_status), .busy(busy)
  );

  mbx_vreg_file #(.VREG_AW(VREG_AW)) u_vreg (
    .clk(clk), .rd_en(mem_rd), .wr_en(mem_wr),
    .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

endmodule

// File: rtl/mbx_vreg_engine_chk.sv
module mbx_vreg_engine_chk #(
  parameter int LATENCY = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       host_wr,
  input logic [3:0] host_addr,
  input logic [7:0] host_wdata,
  input logic       irq,
  input logic       busy,
  input logic       done
);

  logic [31:0] busy_cyc;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cyc <= '0;
    else if (busy_cyc != 32'hFFFF_FFFF) busy_cyc <= busy_cyc + 1;
  end

  // R1
  reset_chk: assert property (@(posedge clk) rst |=> !irq);

  // R11
  latency_window_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cyc >= 32'(LATENCY + 1) && busy_cyc <= 32'(LATENCY + 4)));

  // R7
  done_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> irq);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(done));

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 4'd8 && host_wdata[0] && !done) |=> !irq);

  // R6
  bad_doorbell_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && host_wr && host_addr == 4'd0 && host_wdata != 8'h01) |=> !busy);

  // R6
  busy_doorbell_chk: assert property (@(posedge clk) disable iff (rst)
    (done && host_wr && host_addr == 4'd0 && host_wdata == 8'h01) |=> !busy);

endmodule

bind mbx_vreg_engine mbx_vreg_engine_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .irq(irq), .busy(busy), .done(eng_done)
);

// File: tb/test_mbx_vreg_engine.sv
module test_mbx_vreg_engine;

  localparam int LAT = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       irq;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  mbx_vreg_engine #(.LATENCY(LAT)) i_mbx_vreg_engine (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    hwrite(4'd2, p[7:0]);
    hwrite(4'd3, p[15:8]);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Builds the packet, rings, waits, returns status, byte 4 and the latency, then clears.
  task automatic do_cmd(input logic [7:0] cmd, input logic [15:0] radr, input logic [7:0] val,
                        output logic [7:0] st, output logic [7:0] b4, output int n);
    set_ptr(16'h8000);
    hwrite(4'd4, cmd);
    hwrite(4'd5, 8'h01);
    set_ptr(16'h8004);
    hwrite(4'd4, val);
    hwrite(4'd6, radr[7:0]);
    hwrite(4'd7, radr[15:8]);
    hwrite(4'd0, 8'h01);
    wait_irq(n);
    chk("R10 irq after completion", int'(irq), 1);
    hread(4'd1, st);
    hread(4'd4, b4);
    hwrite(4'd1, st);
    hwrite(4'd8, 8'h01);
  endtask

  task automatic vwrite(input logic [15:0] radr, input logic [7:0] val);
    logic [7:0] st, b4;
    int n;
    do_cmd(8'h03, radr, val, st, b4, n);
    chk("R4 write status", st, 8'h01);
  endtask

  task automatic vread(input logic [15:0] radr, output logic [7:0] val);
    logic [7:0] st;
    int n;
    do_cmd(8'h02, radr, 8'h00, st, val, n);
    chk("R3 read status", st, 8'h01);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 rdata", host_rdata, 0);
    chk("R1 irq", int'(irq), 0);
    hread(4'd1, d); chk("R1 status", d, 0);
    hread(4'd8, d); chk("R1 irq source", d, 0);
    hread(4'd2, d); chk("R1 pointer low", d, 0);
    hread(4'd3, d); chk("R1 pointer high", d, 0);
  endtask

  task automatic t_pointer;
    logic [7:0] d;
    set_ptr(16'h8002);
    hread(4'd2, d); chk("R2 pointer low readback", d, 8'h02);
    hread(4'd3, d); chk("R2 pointer high readback", d, 8'h80);
    hwrite(4'd4, 8'hA5);
    set_ptr(16'h8000);
    hread(4'd6, d); chk("R2 window offset", d, 8'hA5);
    set_ptr(16'h0002);
    hread(4'd4, d); chk("R2 outside region reads zero", d, 0);
    hwrite(4'd4, 8'h77);
    set_ptr(16'h8002);
    hread(4'd4, d); chk("R2 outside region write dropped", d, 8'hA5);
    set_ptr(16'h800E);
    hread(4'd6, d); chk("R2 past buffer end reads zero", d, 0);
  endtask

  task automatic t_write_read;
    logic [7:0] st, b4, d;
    int n;
    do_cmd(8'h03, 16'h0012, 8'h3C, st, b4, n);
    chk("R4 write status ok", st, 8'h01);
    chk("R4 byte 4 kept", b4, 8'h3C);
    chk("R11 write latency in window", int'(n >= LAT + 2 && n <= LAT + 5), 1);
    hread(4'd1, d); chk("R7 status cleared by write-back", d, 0);
    hread(4'd8, d); chk("R7 irq source cleared", d, 0);
    chk("R10 irq low after clear", int'(irq), 0);
    do_cmd(8'h02, 16'h0012, 8'h00, st, b4, n);
    chk("R3 read status ok", st, 8'h01);
    chk("R3 read data", b4, 8'h3C);
    chk("R11 read latency in window", int'(n >= LAT + 2 && n <= LAT + 5), 1);
    vwrite(16'h00FF, 8'hC3);
    vwrite(16'h0000, 8'h5A);
    vread(16'h00FF, d); chk("R3 top register", d, 8'hC3);
    vread(16'h0000, d); chk("R3 bottom register", d, 8'h5A);
    vwrite(16'h1234, 8'h99);
    vread(16'h0034, d); chk("R9 upper address bits ignored", d, 8'h99);
  endtask

  task automatic t_bad_cmd;
    logic [7:0] st, b4, d;
    int n;
    vwrite(16'h0020, 8'h11);
    do_cmd(8'h07, 16'h0020, 8'hEE, st, b4, n);
    chk("R5 error status", st, 8'h80);
    chk("R5 byte 4 unchanged", b4, 8'hEE);
    vread(16'h0020, d); chk("R5 register untouched", d, 8'h11);
  endtask

  task automatic t_doorbell;
    logic [7:0] d;
    int n;
    set_ptr(16'h8000);
    hwrite(4'd4, 8'h03);
    set_ptr(16'h8004);
    hwrite(4'd4, 8'h44);
    hwrite(4'd6, 8'h21);
    hwrite(4'd7, 8'h00);
    hwrite(4'd0, 8'h02);
    repeat (LAT + 10) @(negedge clk);
    chk("R6 wrong doorbell value ignored", int'(irq), 0);
    hwrite(4'd0, 8'h01);
    hwrite(4'd0, 8'h01);
    wait_irq(n);
    chk("R6 first doorbell completes", int'(irq), 1);
    hwrite(4'd1, 8'h01);
    hwrite(4'd8, 8'h01);
    repeat (LAT + 10) @(negedge clk);
    chk("R6 doorbell while busy ignored", int'(irq), 0);
    vread(16'h0021, d); chk("R6 register written once", d, 8'h44);
  endtask

  task automatic t_pair;
    logic [7:0] d;
    logic [7:0] st;
    int n;
    vwrite(16'h0040, 8'h11);
    vwrite(16'h0041, 8'h22);
    do_cmd(8'h02, 16'h0040, 8'h00, st, d, n);
    chk("R8 low byte read", d, 8'h11);
    chk("R11 latching read latency", int'(n >= LAT + 2 && n <= LAT + 5), 1);
    vwrite(16'h0041, 8'h99);
    vread(16'h0041, d); chk("R8 high byte latched", d, 8'h22);
    vread(16'h0041, d); chk("R8 latch persists", d, 8'h22);
    vwrite(16'h0043, 8'h66);
    vread(16'h0043, d); chk("R8 other pair reads stored", d, 8'h66);
    vread(16'h0040, d);
    vread(16'h0041, d); chk("R8 relatched high byte", d, 8'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_write_read();
    t_bad_cmd();
    t_doorbell();
    t_pair();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule